// File: doc/BRIEF.md
# Receive Event-Message Timestamper

This block sits beside the receive byte path of an Ethernet port and timestamps incoming precision-time event messages. It watches the byte stream (one byte per cycle when `rx_valid` is high, with start- and end-of-frame marks) and recognises a time-protocol message in one of three forms: carried directly over Ethernet, inside UDP over IPv4, or inside UDP over IPv6. A single 802.1Q tag ahead of the EtherType is skipped. The local time is sampled on the first byte of every frame. The sample is kept only when the frame turns out to be an event message. In that case it is stored with the message's sequence identifier, its message type and a 12-bit CRC hash of message octets 20 to 29.

Records wait in a small first-in first-out queue. Software sees the oldest record on the read port and removes it with a one-cycle pop. An interrupt output reports that records are waiting, and a sticky flag reports that a record was lost because the queue was full. A mode input switches the UDP match from the precision-time event port to the network-time port. Only one of the two matches is ever active.

Top module: `rxts_top`

## Requirements
- R1: After reset, `rd_avail`, `irq` and `overflow` are all 0.
- R2: A frame with EtherType 0x88F7 at frame bytes 12-13 is parsed as a message starting at byte 14. A version-2 message has octet 1 low nibble = 2. It is an event when octet 0 low nibble < 4. Its record holds `time_now` as sampled on the start-of-frame byte, the sequence identifier from message octets 30 (high) and 31 (low), and the message type from the octet 0 low nibble.
- R3: An IPv4 frame (EtherType 0x0800) is accepted only if IP byte 0 = 0x45, IP byte 9 (protocol) = 17 and the UDP destination port at IP bytes 22-23 = 319. The message then starts at IP byte 28.
- R4: An IPv6 frame (EtherType 0x86DD) is accepted only if IP byte 6 (next header) = 17 and the UDP destination port at IP bytes 42-43 = 319. The message then starts at IP byte 48.
- R5: One tag with EtherType 0x8100 at bytes 12-13 is skipped. The real EtherType is then read at bytes 16-17, and every later offset moves by 4.
- R6: No record is written for any of these: an unknown EtherType, a wrong UDP port or protocol, or a version-2 message type of 4 or more.
- R7: A version-1 message has octet 1 = 0x01. It is an event when octet 20 = 0x01. Its record takes the message type from the low nibble of octet 32 and the sequence identifier from octets 30-31.
- R8: The record hash is a CRC-12 with polynomial x^12+x^11+x^3+x^2+x+1. It starts from zero and runs over message octets 20 through 29, each octet processed most significant bit first.
- R9: With `cfg_ntp_mode` = 1, only UDP frames to port 123 are recorded, whatever their content. The type field is the octet 0 low nibble, and the sequence field is octets 30-31. Direct-Ethernet frames and port-319 frames are then ignored.
- R10: The queue holds 4 records and presents them oldest first. `rd_pop` while `rd_avail` = 1 advances to the next record, and `rd_pop` while empty has no effect. The head record stays steady until it is popped.
- R11: An event frame that ends while the queue is full is dropped and sets `overflow`. `overflow` stays set until reset.
- R12: `irq` is 1 exactly when `rd_avail` = 1 and `cfg_irq_en` was 1 in the previous cycle.
- R13: A frame that ends before the sequence identifier is complete (message octet 31) produces no record. For version 1 the same holds for a frame that ends before octet 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Receive byte |
| time_now | input | TS_W | Free-running local time |
| cfg_ntp_mode | input | 1 | 1: match UDP port 123 instead of 319 |
| cfg_irq_en | input | 1 | Interrupt enable |
| rd_pop | input | 1 | Remove the head record |
| rd_avail | output | 1 | A record is at the head |
| rd_ts | output | TS_W | Head record timestamp |
| rd_seq | output | 16 | Head record sequence identifier |
| rd_msgtype | output | 4 | Head record message type |
| rd_hash | output | 12 | Head record header hash |
| irq | output | 1 | Record-ready interrupt |
| overflow | output | 1 | Sticky record-lost flag |

## Verification
The hardest state to reach from the ports is a full queue that still receives another event frame. Only then does the drop path run and `overflow` get set. To reach it, the bench stops its monitor from popping, sends five event frames back to back, and checks that the first four come out intact and in order once popping resumes. Other hard cases are a frame cut off between the hash octets and the sequence identifier, a version-1 frame cut off just before its control octet, and a pop issued while the queue is empty. Each of these is built byte by byte, and the result is observed through the read port.

// File: rtl/rxts_pkg.sv
package rxts_pkg;
  localparam logic [15:0] ET_VLAN = 16'h8100;
  localparam logic [15:0] ET_PTP  = 16'h88F7;
  localparam logic [15:0] ET_IP4  = 16'h0800;
  localparam logic [15:0] ET_IP6  = 16'h86DD;
  localparam logic [15:0] PORT_EVT = 16'd319;
  localparam logic [15:0] PORT_NTP = 16'd123;
  localparam logic [7:0]  IP_PROTO_UDP = 8'd17;
  localparam logic [7:0]  IP4_VER_IHL  = 8'h45;

  typedef enum logic [2:0] {
    ENC_NONE,
    ENC_L2,
    ENC_IP4,
    ENC_IP6,
    ENC_BAD
  } encap_e;

  typedef struct packed {
    logic [15:0] seq;
    logic [3:0]  mtype;
    logic [11:0] hash;
  } rec_meta_t;
endpackage

// File: rtl/rxts_crc12.sv
module rxts_crc12 #(
  parameter int          CRC_W = 12,
  parameter logic [11:0] POLY  = 12'h80F
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_o
);
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_i;
    for (int b = 7; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ byte_i[b];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/rxts_parser.sv
module rxts_parser
  import rxts_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rx_valid,
  input  logic      rx_sof,
  input  logic      rx_eof,
  input  logic [7:0] rx_data,
  input  logic      ntp_mode,
  output logic      done,
  output logic      hit,
  output rec_meta_t meta
);
  localparam logic [CNT_W-1:0] IDX_MAX = '1;
  localparam logic [CNT_W-1:0] OFS_IP4_MSG = CNT_W'(28);
  localparam logic [CNT_W-1:0] OFS_IP6_MSG = CNT_W'(48);

  logic [CNT_W-1:0] idx, l3_start, msg_start, rel, moff;
  logic             in_frame, vlan, hdr_ok, seq_ok, ctrl_ok, v1evt;
  encap_e           enc;
  logic [7:0]       et_hi, port_hi, seq_hi;
  logic [15:0]      et_w, port_w, port_sel;
  logic [15:0]      seq_q;
  logic [3:0]       b0_q, ver_q, ctrl_q;
  logic [11:0]      crc_q, crc_nx;
  logic             msg_on, v2_evt, v1_evt;

  assign et_w     = {et_hi, rx_data};
  assign port_w   = {port_hi, rx_data};
  assign port_sel = ntp_mode ? PORT_NTP : PORT_EVT;
  assign rel      = idx - l3_start;
  assign moff     = idx - msg_start;
  assign msg_on   = hdr_ok && (idx >= msg_start);

  rxts_crc12 u_crc (
    .crc_i (crc_q),
    .byte_i(rx_data),
    .crc_o (crc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      l3_start  <= '0;
      msg_start <= '0;
      in_frame  <= 1'b0;
      vlan      <= 1'b0;
      hdr_ok    <= 1'b0;
      seq_ok    <= 1'b0;
      ctrl_ok   <= 1'b0;
      v1evt     <= 1'b0;
      enc       <= ENC_NONE;
      et_hi     <= '0;
      port_hi   <= '0;
      seq_hi    <= '0;
      seq_q     <= '0;
      b0_q      <= '0;
      ver_q     <= '0;
      ctrl_q    <= '0;
      crc_q     <= '0;
      done      <= 1'b0;
    end else begin
      done <= rx_valid && rx_eof && (in_frame || rx_sof);
      if (rx_valid && rx_sof) begin
        idx      <= CNT_W'(1);
        in_frame <= !rx_eof;
        vlan     <= 1'b0;
        hdr_ok   <= 1'b0;
        seq_ok   <= 1'b0;
        ctrl_ok  <= 1'b0;
        v1evt    <= 1'b0;
        enc      <= ENC_NONE;
        crc_q    <= '0;
      end else if (rx_valid && in_frame) begin
        if (rx_eof) in_frame <= 1'b0;
        if (idx != IDX_MAX) idx <= idx + 1'b1;

        // EtherType, with one optional tag in front of it
        if (enc == ENC_NONE) begin
          if ((idx == CNT_W'(12)) || (vlan && idx == CNT_W'(16))) et_hi <= rx_data;
          if ((!vlan && idx == CNT_W'(13)) || (vlan && idx == CNT_W'(17))) begin
            if (et_w == ET_VLAN && !vlan) begin
              vlan <= 1'b1;
            end else if (et_w == ET_PTP) begin
              enc       <= ntp_mode ? ENC_BAD : ENC_L2;
              hdr_ok    <= !ntp_mode;
              msg_start <= idx + 1'b1;
            end else if (et_w == ET_IP4) begin
              enc       <= ENC_IP4;
              l3_start  <= idx + 1'b1;
              msg_start <= idx + 1'b1 + OFS_IP4_MSG;
            end else if (et_w == ET_IP6) begin
              enc       <= ENC_IP6;
              l3_start  <= idx + 1'b1;
              msg_start <= idx + 1'b1 + OFS_IP6_MSG;
            end else begin
              enc <= ENC_BAD;
            end
          end
        end

        // IPv4 header and UDP destination port
        if (enc == ENC_IP4 && !hdr_ok) begin
          if (rel == CNT_W'(0) && rx_data != IP4_VER_IHL) enc <= ENC_BAD;
          if (rel == CNT_W'(9) && rx_data != IP_PROTO_UDP) enc <= ENC_BAD;
          if (rel == CNT_W'(22)) port_hi <= rx_data;
          if (rel == CNT_W'(23)) begin
            if (port_w == port_sel) hdr_ok <= 1'b1;
            else enc <= ENC_BAD;
          end
        end

        // IPv6 header and UDP destination port
        if (enc == ENC_IP6 && !hdr_ok) begin
          if (rel == CNT_W'(6) && rx_data != IP_PROTO_UDP) enc <= ENC_BAD;
          if (rel == CNT_W'(42)) port_hi <= rx_data;
          if (rel == CNT_W'(43)) begin
            if (port_w == port_sel) hdr_ok <= 1'b1;
            else enc <= ENC_BAD;
          end
        end

        // message body fields
        if (msg_on) begin
          if (moff == CNT_W'(0)) b0_q <= rx_data[3:0];
          if (moff == CNT_W'(1)) ver_q <= rx_data[3:0];
          if (moff >= CNT_W'(20) && moff <= CNT_W'(29)) crc_q <= crc_nx;
          if (moff == CNT_W'(20)) v1evt <= (rx_data == 8'h01);
          if (moff == CNT_W'(30)) seq_hi <= rx_data;
          if (moff == CNT_W'(31)) begin
            seq_q  <= {seq_hi, rx_data};
            seq_ok <= 1'b1;
          end
          if (moff == CNT_W'(32)) begin
            ctrl_q  <= rx_data[3:0];
            ctrl_ok <= 1'b1;
          end
        end
      end
    end
  end

  assign v2_evt = (ver_q == 4'd2) && (b0_q < 4'd4);
  assign v1_evt = (ver_q == 4'd1) && v1evt && ctrl_ok;

  always_comb begin
    hit        = 1'b0;
    meta.seq   = seq_q;
    meta.hash  = crc_q;
    meta.mtype = b0_q;
    if (hdr_ok && seq_ok && enc != ENC_BAD) begin
      if (ntp_mode) begin
        hit = (enc == ENC_IP4) || (enc == ENC_IP6);
      end else if (v2_evt) begin
        hit = 1'b1;
      end else if (v1_evt) begin
        hit        = 1'b1;
        meta.mtype = ctrl_q;
      end
    end
  end
endmodule

// File: rtl/rxts_queue.sv
module rxts_queue #(
  parameter int W     = 80,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic         avail,
  output logic         avail_nx,
  output logic [W-1:0] rdata,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_next;
  logic [CW-1:0] count, count_nx;
  logic          push_ok, pop_ok;

  assign push_ok  = push && (count != FULL_CNT);
  assign pop_ok   = pop && (count != '0);
  assign drop     = push && !push_ok;
  assign rd_next  = rd_ptr + AW'(pop_ok);
  assign count_nx = count + CW'(push_ok) - CW'(pop_ok);
  assign avail_nx = (count_nx != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
    rdata <= (push_ok && wr_ptr == rd_next) ? wdata : mem[rd_next];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      avail  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_next;
      count  <= count_nx;
      avail  <= avail_nx;
    end
  end
endmodule

// File: rtl/rxts_top.sv
module rxts_top
  import rxts_pkg::*;
#(
  parameter int TS_W  = 48,
  parameter int DEPTH = 4,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_valid,
  input  logic            rx_sof,
  input  logic            rx_eof,
  input  logic [7:0]      rx_data,
  input  logic [TS_W-1:0] time_now,
  input  logic            cfg_ntp_mode,
  input  logic            cfg_irq_en,
  input  logic            rd_pop,
  output logic            rd_avail,
  output logic [TS_W-1:0] rd_ts,
  output logic [15:0]     rd_seq,
  output logic [3:0]      rd_msgtype,
  output logic [11:0]     rd_hash,
  output logic            irq,
  output logic            overflow
);
  localparam int REC_W = TS_W + $bits(rec_meta_t);

  logic            p_done, p_hit, q_push, q_drop, q_avail_nx;
  rec_meta_t       p_meta, h_meta;
  logic [TS_W-1:0] ts_q;
  logic [REC_W-1:0] q_wdata, q_rdata;

  always_ff @(posedge clk) begin
    if (rst) ts_q <= '0;
    else if (rx_valid && rx_sof) ts_q <= time_now;
  end

  rxts_parser #(.CNT_W(CNT_W)) u_parser (
    .clk     (clk),
    .rst     (rst),
    .rx_valid(rx_valid),
    .rx_sof  (rx_sof),
    .rx_eof  (rx_eof),
    .rx_data (rx_data),
    .ntp_mode(cfg_ntp_mode),
    .done    (p_done),
    .hit     (p_hit),
    .meta    (p_meta)
  );

  assign q_push  = p_done && p_hit;
  assign q_wdata = {ts_q, p_meta};

  rxts_queue #(.W(REC_W), .DEPTH(DEPTH)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .push    (q_push),
    .wdata   (q_wdata),
    .pop     (rd_pop),
    .avail   (rd_avail),
    .avail_nx(q_avail_nx),
    .rdata   (q_rdata),
    .drop    (q_drop)
  );

  assign h_meta     = q_rdata[$bits(rec_meta_t)-1:0];
  assign rd_ts      = q_rdata[REC_W-1 -: TS_W];
  assign rd_seq     = h_meta.seq;
  assign rd_msgtype = h_meta.mtype;
  assign rd_hash    = h_meta.hash;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      overflow <= 1'b0;
    end else begin
      irq <= cfg_irq_en && q_avail_nx;
      if (q_drop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rxts_chk.sv
module rxts_chk #(
  parameter int TS_W = 48
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_irq_en,
  input logic            rd_pop,
  input logic            rd_avail,
  input logic [TS_W-1:0] rd_ts,
  input logic [15:0]     rd_seq,
  input logic [11:0]     rd_hash,
  input logic            irq,
  input logic            overflow
);
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(cfg_irq_en)); // R12
  AST_IRQ_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    irq |-> rd_avail); // R12
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R11
  AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(rd_avail)); // R11
  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rd_avail && !rd_pop) |=> (rd_avail && $stable(rd_ts) && $stable(rd_seq) && $stable(rd_hash))); // R10
endmodule

bind rxts_top rxts_chk #(.TS_W(TS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_irq_en(cfg_irq_en),
  .rd_pop    (rd_pop),
  .rd_avail  (rd_avail),
  .rd_ts     (rd_ts),
  .rd_seq    (rd_seq),
  .rd_hash   (rd_hash),
  .irq       (irq),
  .overflow  (overflow)
);

// File: tb/rxts_top_tb.sv
module rxts_top_tb;
  localparam int TS_W = 48;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]      rx_data = '0;
  logic [TS_W-1:0] tnow = TS_W'(1000);
  logic            cfg_ntp_mode = 1'b0, cfg_irq_en = 1'b0;
  logic            rd_pop = 1'b0;
  logic            rd_avail, irq, overflow;
  logic [TS_W-1:0] rd_ts;
  logic [15:0]     rd_seq;
  logic [3:0]      rd_msgtype;
  logic [11:0]     rd_hash;

  always #2.5 clk = ~clk;
  always @(posedge clk) tnow <= tnow + 1'b1;

  rxts_top #(.TS_W(TS_W)) u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .time_now(tnow), .cfg_ntp_mode(cfg_ntp_mode),
    .cfg_irq_en(cfg_irq_en), .rd_pop(rd_pop), .rd_avail(rd_avail), .rd_ts(rd_ts),
    .rd_seq(rd_seq), .rd_msgtype(rd_msgtype), .rd_hash(rd_hash), .irq(irq),
    .overflow(overflow)
  );

  typedef struct {
    logic [TS_W-1:0] ts;
    logic [15:0]     seq;
    logic [3:0]      mt;
    logic [11:0]     hash;
    string           req;
  } item_t;

  item_t      sb[$];
  logic [7:0] fr[$];
  logic [7:0] msg[$];
  int         n_checks = 0, n_errors = 0;
  bit         mon_en = 1'b1, force_pop = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_hash();
    logic [11:0] c = '0;
    for (int k = 20; k < 30; k++) begin
      for (int b = 7; b >= 0; b--) begin
        logic t;
        t = c[11] ^ msg[k][b];
        c = {c[10:0], 1'b0};
        if (t) c = c ^ 12'h80F;
      end
    end
    return c;
  endfunction

  task automatic make_msg(input int ver, input logic [3:0] mt, input logic [15:0] seq,
                          input logic [7:0] seed, input int len, input bit v1ev);
    msg.delete();
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 7);
      if (i == 0) b = (ver == 2) ? {4'h0, mt} : ((ver == 1) ? 8'h00 : b);
      if (i == 1 && ver != 0) b = 8'(ver);
      if (i == 20 && ver == 1) b = v1ev ? 8'h01 : 8'h02;
      if (i == 30) b = seq[15:8];
      if (i == 31) b = seq[7:0];
      if (i == 32 && ver == 1) b = {4'h0, mt};
      msg.push_back(b);
    end
  endtask

  task automatic put_eth(input logic [15:0] et, input bit vlan);
    fr.delete();
    for (int i = 0; i < 6; i++) fr.push_back(8'h01 + 8'(i));
    for (int i = 0; i < 6; i++) fr.push_back(8'hA0 + 8'(i));
    if (vlan) begin
      fr.push_back(8'h81); fr.push_back(8'h00); fr.push_back(8'h00); fr.push_back(8'h07);
    end
    fr.push_back(et[15:8]); fr.push_back(et[7:0]);
  endtask

  task automatic put_udp(input logic [15:0] port);
    fr.push_back(8'h12); fr.push_back(8'h34);
    fr.push_back(port[15:8]); fr.push_back(port[7:0]);
    for (int i = 0; i < 4; i++) fr.push_back(8'h00);
  endtask

  task automatic put_ip4(input logic [15:0] port, input logic [7:0] proto);
    fr.push_back(8'h45);
    for (int i = 1; i < 20; i++) fr.push_back((i == 9) ? proto : 8'(i * 3));
    put_udp(port);
  endtask

  task automatic put_ip6(input logic [15:0] port, input logic [7:0] nh);
    fr.push_back(8'h60);
    for (int i = 1; i < 40; i++) fr.push_back((i == 6) ? nh : 8'(i + 5));
    put_udp(port);
  endtask

  // drive the frame in fr (with msg appended); push expected record if exp
  task automatic send(input bit exp, input logic [3:0] mt, input logic [15:0] seq,
                      input string req, input bit gap = 1'b1);
    item_t it;
    foreach (msg[i]) fr.push_back(msg[i]);
    for (int i = 0; i < fr.size(); i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == fr.size() - 1);
      rx_data  = fr[i];
      if (i == 0) begin
        it.ts = tnow; it.seq = seq; it.mt = mt; it.req = req;
        it.hash = (msg.size() >= 30) ? ref_hash() : 12'h000;
        if (exp) sb.push_back(it);
      end
    end
    if (gap) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    end
  endtask

  task automatic settle(input string req);
    repeat (14) @(negedge clk);
    chk(sb.size() == 0, req, "expected records still pending", 64'(sb.size()), 64'd0);
  endtask

  task automatic settle_none(input string req);
    repeat (14) @(negedge clk);
    chk(rd_avail == 1'b0, req, "rd_avail after rejected frame", 64'(rd_avail), 64'd0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      rd_pop = 1'b0;
      if (force_pop) begin
        rd_pop = 1'b1;
      end else if (mon_en && rd_avail && !rst) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "unexpected record seq", 64'(rd_seq), 64'd0);
        end else begin
          item_t e;
          e = sb.pop_front();
          chk(rd_ts == e.ts, e.req, "timestamp", 64'(rd_ts), 64'(e.ts));
          chk(rd_seq == e.seq, e.req, "sequence id", 64'(rd_seq), 64'(e.seq));
          chk(rd_msgtype == e.mt, e.req, "message type", 64'(rd_msgtype), 64'(e.mt));
          chk(rd_hash == e.hash, "R8", "hash", 64'(rd_hash), 64'(e.hash));
        end
        rd_pop = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(rd_avail == 0, "R1", "rd_avail after reset", 64'(rd_avail), 0);
    chk(irq == 0, "R1", "irq after reset", 64'(irq), 0);
    chk(overflow == 0, "R1", "overflow after reset", 64'(overflow), 0);

    // R2: direct Ethernet, version 2 Sync
    put_eth(16'h88F7, 0); make_msg(2, 4'd0, 16'h1234, 8'h11, 44, 0); send(1, 4'd0, 16'h1234, "R2");
    settle("R2");
    // R5: tagged direct Ethernet, type 3
    put_eth(16'h8100, 0); fr.delete(); put_eth(16'h88F7, 1);
    make_msg(2, 4'd3, 16'hBEEF, 8'h52, 44, 0); send(1, 4'd3, 16'hBEEF, "R5");
    settle("R5");
    // R3: IPv4
    put_eth(16'h0800, 0); put_ip4(16'd319, 8'd17);
    make_msg(2, 4'd1, 16'h0A0B, 8'h23, 44, 0); send(1, 4'd1, 16'h0A0B, "R3");
    settle("R3");
    // R4 with R5: tagged IPv6
    put_eth(16'h86DD, 1); put_ip6(16'd319, 8'd17);
    make_msg(2, 4'd2, 16'h7788, 8'h9C, 44, 0); send(1, 4'd2, 16'h7788, "R4");
    settle("R4");
    // R7: version 1 over IPv4, control 1
    put_eth(16'h0800, 0); put_ip4(16'd319, 8'd17);
    make_msg(1, 4'd1, 16'h4321, 8'h3D, 44, 1); send(1, 4'd1, 16'h4321, "R7");
    settle("R7");
    // R7: version 1 non-event
    put_eth(16'h0800, 0); put_ip4(16'd319, 8'd17);
    make_msg(1, 4'd0, 16'h0001, 8'h3D, 44, 0); send(0, 4'd0, 16'h0, "R7");
    settle_none("R7");
    // R6: follow-up type, other EtherType, wrong port, wrong protocol
    put_eth(16'h88F7, 0); make_msg(2, 4'd8, 16'h0002, 8'h44, 44, 0); send(0, 0, 0, "R6");
    settle_none("R6");
    put_eth(16'h0806, 0); make_msg(2, 4'd0, 16'h0003, 8'h44, 44, 0); send(0, 0, 0, "R6");
    settle_none("R6");
    put_eth(16'h0800, 0); put_ip4(16'd320, 8'd17);
    make_msg(2, 4'd0, 16'h0004, 8'h44, 44, 0); send(0, 0, 0, "R6");
    settle_none("R6");
    put_eth(16'h86DD, 0); put_ip6(16'd319, 8'd6);
    make_msg(2, 4'd0, 16'h0005, 8'h44, 44, 0); send(0, 0, 0, "R6");
    settle_none("R6");
    // R13: truncated before octet 31, and version 1 truncated before octet 32
    put_eth(16'h88F7, 0); make_msg(2, 4'd0, 16'h0006, 8'h44, 31, 0); send(0, 0, 0, "R13");
    settle_none("R13");
    put_eth(16'h88F7, 0); make_msg(1, 4'd0, 16'h0007, 8'h44, 32, 1); send(0, 0, 0, "R13");
    settle_none("R13");

    // R9: network-time mode
    cfg_ntp_mode = 1'b1;
    put_eth(16'h0800, 0); put_ip4(16'd123, 8'd17);
    make_msg(0, 4'd0, 16'h5566, 8'h23, 40, 0); send(1, 4'h3, 16'h5566, "R9");
    settle("R9");
    put_eth(16'h86DD, 0); put_ip6(16'd123, 8'd17);
    make_msg(0, 4'd0, 16'h99AA, 8'h64, 40, 0); send(1, 4'h4, 16'h99AA, "R9");
    settle("R9");
    put_eth(16'h88F7, 0); make_msg(2, 4'd0, 16'h0008, 8'h44, 44, 0); send(0, 0, 0, "R9");
    settle_none("R9");
    put_eth(16'h0800, 0); put_ip4(16'd319, 8'd17);
    make_msg(2, 4'd0, 16'h0009, 8'h44, 44, 0); send(0, 0, 0, "R9");
    settle_none("R9");
    cfg_ntp_mode = 1'b0;

    // R10: pop while empty has no effect
    @(posedge clk); #1 force_pop = 1'b1;
    @(negedge clk); #1 force_pop = 1'b0;
    @(negedge clk);
    chk(rd_avail == 0, "R10", "rd_avail after empty pop", 64'(rd_avail), 0);
    put_eth(16'h88F7, 0); make_msg(2, 4'd1, 16'h2468, 8'h71, 44, 0); send(1, 4'd1, 16'h2468, "R10");
    settle("R10");

    // R10/R11/R12: fill the queue back to back, then one more
    mon_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      put_eth(16'h88F7, 0); make_msg(2, 4'(k), 16'h3000 + 16'(k), 8'(k * 13), 44, 0);
      send(1, 4'(k), 16'h3000 + 16'(k), "R10", 1'b0);
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (4) @(negedge clk);
    chk(overflow == 0, "R11", "overflow with queue just full", 64'(overflow), 0);
    chk(irq == 0, "R12", "irq while disabled", 64'(irq), 0);
    put_eth(16'h88F7, 0); make_msg(2, 4'd0, 16'h3FFF, 8'h05, 44, 0); send(0, 0, 0, "R11");
    repeat (4) @(negedge clk);
    chk(overflow == 1, "R11", "overflow after drop", 64'(overflow), 1);
    chk(rd_avail == 1, "R10", "rd_avail with queue full", 64'(rd_avail), 1);
    cfg_irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1, "R12", "irq after enable", 64'(irq), 1);
    mon_en = 1'b1;
    settle("R10");
    chk(irq == 0, "R12", "irq after drain", 64'(irq), 0);
    chk(overflow == 1, "R11", "overflow stays set", 64'(overflow), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule